// File: doc/BRIEF.md
# Receive Bit Buffer with Serial Host Readout

This block collects demodulated receive bits in a small first-in-first-out buffer and hands them to a host over a serial link. Each receive bit arrives with a one-cycle strobe. The host reads stored bits in one of two ways. The first is a dedicated active-low buffer select: while it is low, the serial output shows the oldest stored bit, and every falling edge of the serial clock moves on to the next bit. The second is a status read, in which a 16-bit status word goes out MSB first and the buffered bits follow it in the same transfer.

A level-type interrupt output goes high when the number of stored bits equals a programmable fill threshold. It stays high until the buffer has been fully drained, so the host may also poll it as a data-ready indication. All logic runs on one system clock. The serial clock and both selects are sampled as ordinary synchronous inputs, and the serial clock must hold each level for at least one system clock cycle.

Top module: `rxf_readout`

## Requirements
- R1: A bit presented with `rx_vld` high at a clock edge is stored. While `fifo_sel_n` is low, `sdo` shows the oldest stored bit, and each falling edge of `sck` (seen on the system clock) removes that bit so that `sdo` shows the next one, in arrival order.
- R2: A read edge while the buffer is empty changes nothing: `sdo` stays 0 and the stored count stays 0.
- R3: A strobe that arrives while 16 bits are held is dropped, and the overflow flag is set and stays set.
- R4: `fifo_irq` rises at the same clock edge at which the stored count becomes equal to the threshold. The threshold is `fill_lim`, and a value of 0 means 16.
- R5: Once high, `fifo_irq` stays high until the stored count returns to 0, and falls at that same edge.
- R6: At the clock edge where `stat_sel_n` is first seen low, a status word is captured. Its bits are: 15 interrupt, 14 overflow, 13 full, 12 empty, 11:7 stored count, 6:3 `fill_lim`, 2:0 zero. The word goes out on `sdo` MSB first, and each `sck` falling edge moves on by one bit.
- R7: After the 16 status bits, later `sck` falling edges in the same status read output and remove buffered bits exactly as in R1.
- R8: Capturing the status word clears the overflow flag, unless a drop happens at the same edge.
- R9: `sdo` is 0 whenever both selects are high. When both are low, the buffer-select path takes precedence.
- R10: A store and a removal at the same edge, with the buffer neither full nor empty, both take effect and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_vld | input | 1 | Receive bit strobe |
| rx_bit | input | 1 | Receive bit value |
| fill_lim | input | 4 | Interrupt fill threshold (0 means 16) |
| sck | input | 1 | Serial clock from the host |
| fifo_sel_n | input | 1 | Active-low direct buffer select |
| stat_sel_n | input | 1 | Active-low status-read select |
| sdo | output | 1 | Serial data out |
| fifo_irq | output | 1 | Fill-level interrupt, active high |

## Verification
The hardest case to reach from the ports is a status transfer that crosses from the status word into buffer data while the interrupt is still pending and the overflow flag is set. To get there, the buffer must first be overfilled with a threshold of 0, the flag must then be captured and cleared, and the remaining bits must be drained in that same transfer. The directed sequence builds this state on purpose. Randomly mixed strobes, reads of varying length, status reads with trailing buffer bits and threshold changes then cover the other states, and a bench queue model predicts every output.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int STAT_W = 16;

  typedef struct packed {
    logic       irq;
    logic       ovf;
    logic       full;
    logic       empty;
    logic [4:0] level;
    logic [3:0] limit;
    logic [2:0] zero;
  } rxf_stat_t;

  // threshold of zero selects the full depth
  function automatic int rxf_eff_limit(input int lim, input int depth);
    return (lim == 0) ? depth : lim;
  endfunction

  function automatic logic [STAT_W-1:0] rxf_pack(
    input logic       irq,
    input logic       ovf,
    input logic       full,
    input logic       empty,
    input logic [4:0] level,
    input logic [3:0] limit
  );
    rxf_stat_t s;
    s.irq   = irq;
    s.ovf   = ovf;
    s.full  = full;
    s.empty = empty;
    s.level = level;
    s.limit = limit;
    s.zero  = 3'b000;
    return s;
  endfunction

endpackage

// File: rtl/rxf_sense.sv
module rxf_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic stat_sel_n,
  output logic sck_fall,
  output logic stat_start
);
  logic sck_q;
  logic stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      stat_q <= 1'b1;
    end else begin
      sck_q  <= sck;
      stat_q <= stat_sel_n;
    end
  end

  assign sck_fall   = sck_q & ~sck;
  assign stat_start = stat_q & ~stat_sel_n;
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          din,
  input  logic          pop,
  output logic          head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] cnt_nxt,
  output logic          full,
  output logic          empty,
  output logic          drop
);
  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    rd_ptr;
  logic [AW-1:0]    wr_ptr;
  logic             push_ok;
  logic             pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + AW'(1);
  endfunction

  assign full    = (int'(count) == DEPTH);
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign drop    = push & full;
  assign head    = empty ? 1'b0 : mem[rd_ptr];
  assign cnt_nxt = count + CW'(push_ok) - CW'(pop_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem    <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop_ok) rd_ptr <= bump(rd_ptr);
      count <= cnt_nxt;
    end
  end

  // R2
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0));
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) <= DEPTH));
  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (int'(count) == DEPTH));
  // R10
  both_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty) |=> $stable(count));
endmodule

// File: rtl/rxf_irq.sv
module rxf_irq #(
  parameter int DEPTH = 16,
  parameter int LIM_W = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cnt_q,
  input  logic [CW-1:0]    cnt_nxt,
  input  logic [LIM_W-1:0] limit,
  output logic             irq
);
  import rxf_pkg::*;

  logic [CW-1:0] lim_eff;
  logic          hit;
  logic          drained;

  assign lim_eff = CW'(rxf_eff_limit(int'(limit), DEPTH));
  assign hit     = (cnt_nxt == lim_eff);
  assign drained = (cnt_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (hit)     irq <= 1'b1;
    else if (drained) irq <= 1'b0;
  end

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (cnt_q == $past(lim_eff)));
  // R5
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> (cnt_q == '0));
endmodule

// File: rtl/rxf_stat_shift.sv
module rxf_stat_shift #(
  parameter int SW = 16,
  localparam int IW = $clog2(SW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] word,
  input  logic          active,
  input  logic          adv,
  output logic          bit_out,
  output logic          done
);
  logic [SW-1:0] shreg;
  logic [IW-1:0] idx;

  assign done    = (int'(idx) == SW);
  assign bit_out = shreg[SW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      idx   <= IW'(SW);
    end else if (load) begin
      shreg <= word;
      idx   <= '0;
    end else if (!active) begin
      idx   <= IW'(SW);
    end else if (adv && !done) begin
      shreg <= shreg << 1;
      idx   <= idx + IW'(1);
    end
  end

  // R6
  stat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx == '0));
  // R7
  stat_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(idx) <= SW));
endmodule

// File: rtl/rxf_readout.sv
module rxf_readout #(
  parameter int DEPTH = 16,
  parameter int LIM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_vld,
  input  logic             rx_bit,
  input  logic [LIM_W-1:0] fill_lim,
  input  logic             sck,
  input  logic             fifo_sel_n,
  input  logic             stat_sel_n,
  output logic             sdo,
  output logic             fifo_irq
);
  import rxf_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  logic          sck_fall;
  logic          stat_start;
  logic          fifo_act;
  logic          stat_act;
  logic          stat_done;
  logic          stat_bit;
  logic          stat_adv;
  logic          pop;
  logic          head;
  logic          full;
  logic          empty;
  logic          drop;
  logic          ovf;
  logic [CW-1:0] count;
  logic [CW-1:0] cnt_nxt;
  logic [STAT_W-1:0] stat_word;

  rxf_sense u_sense (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck        (sck),
    .stat_sel_n (stat_sel_n),
    .sck_fall   (sck_fall),
    .stat_start (stat_start)
  );

  assign fifo_act = ~fifo_sel_n;
  assign stat_act = ~stat_sel_n & fifo_sel_n;
  assign pop      = sck_fall & (fifo_act | (stat_act & stat_done));
  assign stat_adv = sck_fall & stat_act & ~stat_done;

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (rx_vld),
    .din     (rx_bit),
    .pop     (pop),
    .head    (head),
    .count   (count),
    .cnt_nxt (cnt_nxt),
    .full    (full),
    .empty   (empty),
    .drop    (drop)
  );

  rxf_irq #(.DEPTH(DEPTH), .LIM_W(LIM_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_q   (count),
    .cnt_nxt (cnt_nxt),
    .limit   (fill_lim),
    .irq     (fifo_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovf <= 1'b0;
    else if (drop)       ovf <= 1'b1;
    else if (stat_start) ovf <= 1'b0;
  end

  assign stat_word = rxf_pack(fifo_irq, ovf, full, empty, 5'(count), 4'(fill_lim));

  rxf_stat_shift #(.SW(STAT_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (stat_start),
    .word    (stat_word),
    .active  (~stat_sel_n),
    .adv     (stat_adv),
    .bit_out (stat_bit),
    .done    (stat_done)
  );

  always_comb begin
    if (fifo_act)      sdo = head;
    else if (stat_act) sdo = stat_done ? head : stat_bit;
    else               sdo = 1'b0;
  end

  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf);
  // R8
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_start && !drop) |=> !ovf);
  // R9
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_sel_n && stat_sel_n) |-> !sdo);
endmodule

// File: tb/tb_rxf_readout.sv
module tb_rxf_readout;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_vld = 1'b0;
  logic       rx_bit = 1'b0;
  logic [3:0] fill_lim = 4'd0;
  logic       sck = 1'b0;
  logic       fifo_sel_n = 1'b1;
  logic       stat_sel_n = 1'b1;
  logic       sdo;
  logic       fifo_irq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  bit q[$];
  bit irq_m = 0;
  bit ovf_m = 0;

  always #5 clk = ~clk;

  rxf_readout dut (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_bit(rx_bit),
    .fill_lim(fill_lim), .sck(sck), .fifo_sel_n(fifo_sel_n),
    .stat_sel_n(stat_sel_n), .sdo(sdo), .fifo_irq(fifo_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int thr(input logic [3:0] l);
    if (l == 4'd0) return 16;
    return int'(l);
  endfunction

  task automatic model_irq();
    if (q.size() == thr(fill_lim)) irq_m = 1;
    else if (q.size() == 0) irq_m = 0;
  endtask

  task automatic sck_pulse();
    sck = 1'b1;
    @(negedge clk);
    sck = 1'b0;
    @(negedge clk);
  endtask

  task automatic push_bit(input bit b);
    rx_bit = b;
    rx_vld = 1'b1;
    @(negedge clk);
    rx_vld = 1'b0;
    if (q.size() == 16) ovf_m = 1;
    else q.push_back(b);
    model_irq();
    check("R4 irq after store", fifo_irq, irq_m);
  endtask

  task automatic drain_bits(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      check(req, sdo, (q.size() != 0) ? q[0] : 1'b0);
      sck_pulse();
      if (q.size() != 0) void'(q.pop_front());
      model_irq();
      check("R5 irq after read", fifo_irq, irq_m);
    end
  endtask

  task automatic read_fifo(input int n);
    fifo_sel_n = 1'b0;
    @(negedge clk);
    drain_bits(n, "R1 fifo bit");
    fifo_sel_n = 1'b1;
    @(negedge clk);
    check("R9 idle sdo", sdo, 0);
  endtask

  task automatic read_status(input int nf);
    logic [15:0] w;
    w = {irq_m, ovf_m, (q.size() == 16), (q.size() == 0),
         5'(q.size()), fill_lim, 3'b000};
    stat_sel_n = 1'b0;
    @(negedge clk);
    ovf_m = 0;
    for (int i = 15; i >= 0; i--) begin
      check("R6 status bit", sdo, w[i]);
      sck_pulse();
    end
    drain_bits(nf, "R7 trailing fifo bit");
    stat_sel_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_lim(input logic [3:0] l);
    fill_lim = l;
    @(negedge clk);
    model_irq();
    check("R4 irq after threshold change", fifo_irq, irq_m);
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset sdo", sdo, 0);
    check("R4 reset irq", fifo_irq, 0);

    // threshold 4: rises on fourth store, stays until empty
    set_lim(4'd4);
    push_bit(1); push_bit(0); push_bit(1);
    check("R4 below threshold", fifo_irq, 0);
    push_bit(1);
    check("R4 at threshold", fifo_irq, 1);
    read_fifo(3);
    check("R5 still pending", fifo_irq, 1);
    read_fifo(1);
    check("R5 cleared at empty", fifo_irq, 0);

    // R2 read on empty
    read_fifo(2);
    read_status(0);

    // threshold 0 means 16, overflow and clear
    set_lim(4'd0);
    for (int i = 0; i < 15; i++) push_bit(i[0]);
    check("R4 zero means 16, not yet", fifo_irq, 0);
    push_bit(1);
    check("R4 zero means 16", fifo_irq, 1);
    push_bit(0); push_bit(0);
    check("R3 count held at 16", int'(q.size()), 16);
    read_status(3);
    read_status(2);

    // R9 precedence: buffer select held while status select also low
    fifo_sel_n = 1'b0;
    @(negedge clk);
    stat_sel_n = 1'b0;
    @(negedge clk);
    ovf_m = 0;
    drain_bits(2, "R9 precedence");
    stat_sel_n = 1'b1;
    fifo_sel_n = 1'b1;
    @(negedge clk);

    // R10 store and removal at the same edge
    fifo_sel_n = 1'b0;
    @(negedge clk);
    check("R10 head before", sdo, q[0]);
    sck = 1'b1;
    @(negedge clk);
    sck = 1'b0;
    rx_vld = 1'b1;
    rx_bit = 1'b1;
    @(negedge clk);
    rx_vld = 1'b0;
    q.push_back(1);
    void'(q.pop_front());
    model_irq();
    fifo_sel_n = 1'b1;
    @(negedge clk);
    read_status(0);
    check("R10 irq", fifo_irq, irq_m);

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 5) push_bit(1'($urandom));
      else if (op < 7) read_fifo($urandom_range(1, 5));
      else if (op < 9) read_status($urandom_range(0, 4));
      else set_lim(4'($urandom));
    end
    read_fifo(20);
    check("R5 drained", fifo_irq, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule